// File: doc/BRIEF.md
# NAND Chunk ECC Syndrome Corrector

This block checks one 512-byte flash data chunk after it has been read. It takes two 24-bit words: the ECC stored in the spare area and the ECC that the data path computed over the chunk. It combines them into a syndrome and sorts the result into one of four classes:

- clean;
- a single flipped data bit that can be repaired;
- damage to the stored ECC itself;
- uncorrectable.

For a repairable error it reports where the bad bit lies. It then repairs the bit through a read-modify-write on an attached 512x8 buffer port.

A request is a one-cycle `start` strobe with both ECC words on the same cycle. The block answers with a one-cycle `done` pulse that carries a 2-bit status. `start`, `done` and the status are plain control and status pins, with no valid/ready handshake. The buffer port has no back-pressure either: the buffer must return read data on the cycle after `buf_rd_en` and must accept a write on the cycle `buf_wr_en` is high. The block is busy from the cycle that accepts a start through its done cycle. A start raised during that time is dropped.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: Each 24-bit ECC word splits into byte 0 = bits 7:0, byte 1 = bits 15:8 and byte 2 = bits 23:16. The syndrome is the stored word XOR the computed word. An all-zero syndrome gives status 2'b00 (clean), with `done` high on the cycle after the accepting clock edge and no buffer access.
- R2: A syndrome is correctable only when, in all three bytes, every bit pair (1,0), (3,2), (5,4), (7,6) holds two different values. A correctable syndrome gives status 2'b01 (fixed).
- R3: The reported bit index `err_bit` takes its bit 0 from syndrome byte 2 bit 2, its bit 1 from byte 2 bit 4, and its bit 2 from byte 2 bit 6.
- R4: The reported byte index `err_byte` is built from three sources:
  - bits 3..0 come from syndrome byte 0 bits 6, 4, 2, 0;
  - bits 7..4 come from syndrome byte 1 bits 6, 4, 2, 0;
  - bit 8 comes from syndrome byte 2 bit 0.
- R5: A correctable error runs the following fixed sequence, with `buf_addr` equal to `err_byte` throughout:
  - the first cycle after acceptance drives `buf_rd_en`;
  - the second cycle drives `buf_wr_en`, with `buf_wdata` equal to the read byte with bit `err_bit` inverted;
  - the third cycle raises `done`.
- R6: A syndrome with exactly one bit set gives status 2'b10 (stored ECC fault). It makes no buffer access, and `done` rises on the cycle after acceptance.
- R7: Every other nonzero syndrome gives status 2'b11 (uncorrectable). It makes no buffer write, and `done` rises on the cycle after acceptance.
- R8: A `start` raised from the cycle after acceptance through the done cycle is ignored. It does not change the status, the indices or the buffer contents.
- R9: While reset is held, and after it is released, `done`, `buf_rd_en` and `buf_wr_en` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | one-cycle request strobe |
| ecc_stored | input | 24 | ECC word read from the spare area |
| ecc_calc | input | 24 | ECC word computed over the chunk |
| done | output | 1 | one-cycle result pulse |
| status | output | 2 | 00 clean, 01 fixed, 10 ECC fault, 11 uncorrectable |
| err_byte | output | 9 | byte index of the bad bit (meaningful when fixed) |
| err_bit | output | 3 | bit index within the byte (meaningful when fixed) |
| buf_addr | output | 9 | buffer byte address |
| buf_rd_en | output | 1 | buffer read request, data due next cycle |
| buf_rdata | input | 8 | buffer read data |
| buf_wr_en | output | 1 | buffer write strobe |
| buf_wdata | output | 8 | buffer write data |

## Verification
A clean, ECC-fault or uncorrectable result is due one cycle after the accepting clock edge. A fixed result is due three cycles after it, with the read on the first cycle and the write on the second. The bench steps a behavioural phase model on every rising edge from the same inputs. On every falling edge it compares `done`, `buf_rd_en` and `buf_wr_en` with that model, and on the write cycle it also compares the address and data. On the done cycle it compares the status and indices. At the end it compares the whole buffer image with the model's own copy, which shows that dropped starts and non-fixable classes left the data untouched.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int BYTE_W   = 8;
  localparam int ECC_NB   = 3;
  localparam int ECC_W    = BYTE_W * ECC_NB;
  localparam int CHUNK    = 512;
  localparam int ADDR_W   = $clog2(CHUNK);
  localparam int BIDX_W   = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_ECCBAD = 2'd2,
    ST_UNCORR = 2'd3
  } fix_status_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_READ,
    PH_WRITE,
    PH_FIN
  } fix_phase_t;
endpackage

// File: rtl/ecc_pair_check.sv
module ecc_pair_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         ok
);
  localparam int NPAIR = W / 2;
  logic [NPAIR-1:0] differs;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    assign differs[k] = d[2*k] ^ d[2*k+1];
  end

  assign ok = &differs;
endmodule

// File: rtl/ecc_syndrome_decode.sv
module ecc_syndrome_decode
  import ecc_fix_pkg::*;
(
  input  logic [ECC_W-1:0]  stored,
  input  logic [ECC_W-1:0]  calc,
  output fix_status_t       cls,
  output logic [ADDR_W-1:0] byte_idx,
  output logic [BIDX_W-1:0] bit_idx
);
  localparam int HALF = BYTE_W / 2;

  logic [BYTE_W-1:0] syn [ECC_NB];
  logic [ECC_NB-1:0] pair_ok;
  logic [ECC_W-1:0]  syn_w;
  logic              is_zero, is_single;

  assign syn_w = stored ^ calc;

  for (genvar b = 0; b < ECC_NB; b++) begin : g_byte
    assign syn[b] = syn_w[b*BYTE_W +: BYTE_W];
    ecc_pair_check #(.W(BYTE_W)) u_pair (.d(syn[b]), .ok(pair_ok[b]));
  end

  // even-position bits carry the index; odd ones are their complements
  for (genvar k = 0; k < HALF; k++) begin : g_idx
    assign byte_idx[k]        = syn[0][2*k];
    assign byte_idx[HALF + k] = syn[1][2*k];
  end
  assign byte_idx[ADDR_W-1] = syn[2][0];

  for (genvar k = 0; k < BIDX_W; k++) begin : g_bit
    assign bit_idx[k] = syn[2][2*k+2];
  end

  assign is_zero   = (syn_w == '0);
  assign is_single = !is_zero && ((syn_w & (syn_w - 1'b1)) == '0);

  always_comb begin
    if (is_zero)         cls = ST_CLEAN;
    else if (&pair_ok)   cls = ST_FIXED;
    else if (is_single)  cls = ST_ECCBAD;
    else                 cls = ST_UNCORR;
  end
endmodule

// File: rtl/ecc_fix_ctrl.sv
module ecc_fix_ctrl
  import ecc_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  fix_status_t       cls_in,
  input  logic [ADDR_W-1:0] byte_in,
  input  logic [BIDX_W-1:0] bit_in,
  output logic              done,
  output fix_status_t       status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [BIDX_W-1:0] err_bit,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_wr_en,
  output logic [BYTE_W-1:0] buf_wdata
);
  fix_phase_t phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      status   <= ST_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          status   <= cls_in;
          err_byte <= byte_in;
          err_bit  <= bit_in;
          phase    <= (cls_in == ST_FIXED) ? PH_READ : PH_FIN;
        end
        PH_READ:  phase <= PH_WRITE;
        PH_WRITE: phase <= PH_FIN;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign done      = (phase == PH_FIN);
  assign buf_rd_en = (phase == PH_READ);
  assign buf_wr_en = (phase == PH_WRITE);
  assign buf_addr  = err_byte;
  assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << err_bit);
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_fix_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ECC_W-1:0]  ecc_stored,
  input  logic [ECC_W-1:0]  ecc_calc,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [BIDX_W-1:0] err_bit,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  input  logic [BYTE_W-1:0] buf_rdata,
  output logic              buf_wr_en,
  output logic [BYTE_W-1:0] buf_wdata
);
  fix_status_t       cls, st;
  logic [ADDR_W-1:0] dec_byte;
  logic [BIDX_W-1:0] dec_bit;

  ecc_syndrome_decode u_dec (
    .stored  (ecc_stored),
    .calc    (ecc_calc),
    .cls     (cls),
    .byte_idx(dec_byte),
    .bit_idx (dec_bit)
  );

  ecc_fix_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cls_in   (cls),
    .byte_in  (dec_byte),
    .bit_in   (dec_bit),
    .done     (done),
    .status   (st),
    .err_byte (err_byte),
    .err_bit  (err_bit),
    .buf_addr (buf_addr),
    .buf_rd_en(buf_rd_en),
    .buf_rdata(buf_rdata),
    .buf_wr_en(buf_wr_en),
    .buf_wdata(buf_wdata)
  );

  assign status = st;
endmodule

// File: rtl/ecc_syndrome_corrector_chk.sv
module ecc_syndrome_corrector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [1:0] status,
  input logic [8:0] buf_addr,
  input logic       buf_rd_en,
  input logic [7:0] buf_rdata,
  input logic       buf_wr_en,
  input logic [7:0] buf_wdata
);
  a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |=> buf_wr_en);

  a_r5_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> (done && status == 2'd1));

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> (buf_addr == $past(buf_addr)));

  a_r5_one_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));

  a_r7_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd1) |-> ($past(start) && !$past(buf_wr_en)));

  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_rd_en, buf_wr_en, done}));
endmodule

bind ecc_syndrome_corrector ecc_syndrome_corrector_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .status   (status),
  .buf_addr (buf_addr),
  .buf_rd_en(buf_rd_en),
  .buf_rdata(buf_rdata),
  .buf_wr_en(buf_wr_en),
  .buf_wdata(buf_wdata)
);

// File: tb/ecc_syndrome_corrector_tb.sv
module ecc_syndrome_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ecc_stored = '0, ecc_calc = '0;
  logic        done, buf_rd_en, buf_wr_en;
  logic [1:0]  status;
  logic [8:0]  err_byte, buf_addr;
  logic [2:0]  err_bit;
  logic [7:0]  buf_rdata = '0, buf_wdata;

  int n_checks = 0, n_fail = 0, cycles = 0;

  always #5 clk = ~clk;

  ecc_syndrome_corrector dut_i (.*);

  // attached buffer: synchronous read, one-cycle latency
  logic [7:0] mem   [512];
  logic [7:0] m_mem [512];
  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural expectations
  function automatic int classify(logic [23:0] s);
    int ones = 0;
    bit pairs = 1;
    for (int i = 0; i < 24; i++) ones += s[i];
    for (int i = 0; i < 24; i += 2) if (s[i] == s[i+1]) pairs = 0;
    if (ones == 0) return 0;
    if (pairs) return 1;
    if (ones == 1) return 2;
    return 3;
  endfunction

  function automatic int exp_byte(logic [23:0] s);
    int r = 0;
    for (int k = 0; k < 4; k++) begin
      r += s[2*k] << k;
      r += s[8 + 2*k] << (4 + k);
    end
    r += s[16] << 8;
    return r;
  endfunction

  function automatic int exp_bit(logic [23:0] s);
    int r = 0;
    for (int k = 0; k < 3; k++) r += s[16 + 2*k + 2] << k;
    return r;
  endfunction

  function automatic logic [23:0] make_syn(int byt, int bt);
    logic [23:0] s = '0;
    int v;
    for (int p = 0; p < 12; p++) begin
      if (p < 4)       v = (byt >> p) & 1;
      else if (p < 8)  v = (byt >> p) & 1;
      else if (p == 8) v = (byt >> 8) & 1;
      else             v = (bt >> (p - 9)) & 1;
      s[2*p]   = v[0];
      s[2*p+1] = ~v[0];
    end
    return s;
  endfunction

  // cycle model: 0 idle, 1 read, 2 write, 3 done
  int m_ph = 0, m_cls = 0, m_byte = 0, m_bit = 0;
  string m_tag = "R9";
  always @(posedge clk) begin
    if (!rst_n) m_ph <= 0;
    else case (m_ph)
      0: if (start) begin
        m_cls  <= classify(ecc_stored ^ ecc_calc);
        m_byte <= exp_byte(ecc_stored ^ ecc_calc);
        m_bit  <= exp_bit(ecc_stored ^ ecc_calc);
        m_ph   <= (classify(ecc_stored ^ ecc_calc) == 1) ? 1 : 3;
      end
      1: m_ph <= 2;
      2: begin
        m_mem[m_byte] <= m_mem[m_byte] ^ (8'd1 << m_bit);
        m_ph <= 3;
      end
      default: m_ph <= 0;
    endcase
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({m_tag, " done"}, done, m_ph == 3);
      chk({m_tag, " rd_en"}, buf_rd_en, m_ph == 1);
      chk({m_tag, " wr_en"}, buf_wr_en, m_ph == 2);
      if (m_ph == 2) begin
        chk("R5 write addr", buf_addr, m_byte);
        chk("R5 write data", buf_wdata, m_mem[m_byte] ^ (8'd1 << m_bit));
      end
      if (m_ph == 3) begin
        chk({m_tag, " status"}, status, m_cls);
        if (m_cls == 1) begin
          chk("R4 err_byte", err_byte, m_byte);
          chk("R3 err_bit", err_bit, m_bit);
        end
      end
    end
  end

  task automatic run(logic [23:0] st, logic [23:0] syn, string tag);
    @(negedge clk);
    m_tag = tag;
    ecc_stored = st;
    ecc_calc   = st ^ syn;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]   = 8'(i * 37 + 5);
      m_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    chk("R9 reset done", done, 0);
    chk("R9 reset rd_en", buf_rd_en, 0);
    chk("R9 reset wr_en", buf_wr_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(24'h3C5A96, 24'h000000, "R1");
    run(24'hFFFFFF, 24'h000000, "R1");
    run(24'h123456, make_syn(0, 0), "R2");
    run(24'hA5A5A5, make_syn(511, 7), "R2");
    run(24'h0F0F0F, make_syn(9'h155, 5), "R4");
    run(24'h000000, make_syn(9'h0AA, 2), "R3");
    run(24'h777777, make_syn(9'h0AA, 2), "R5");
    run(24'h010203, 24'h000001, "R6");
    run(24'h010203, 24'h800000, "R6");
    run(24'h010203, 24'h001000, "R6");
    run(24'h445566, 24'h000003, "R7");
    run(24'h445566, 24'hFFFFFF, "R7");
    run(24'h445566, make_syn(3, 1) ^ 24'h000100, "R7");

    // R8: starts held during a correction and its done cycle are dropped
    @(negedge clk);
    m_tag = "R8";
    ecc_stored = 24'h0;
    ecc_calc   = make_syn(100, 4);
    start      = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ecc_calc = make_syn(200 + i, 1);
    end
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 other byte untouched", mem[201], m_mem[201]);

    for (int i = 0; i < 512; i++) chk("R8 buffer image", mem[i], m_mem[i]);
    chk("R6 fault left data", mem[0] ^ mem[511], m_mem[0] ^ m_mem[511]);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_checks++;
    n_fail++;
    $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 20000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule